// File: doc/BRIEF.md
# Event-to-Counter Mapping Table

This block records which programmable hardware counter has been assigned to each supported performance event. Configuration software writes an event selector to a counter index. The block checks that the index is usable and that the event is one it knows. It then stores the pairing in a small table with one entry per event. The first counter bound to an event keeps that event. Writing a zero selector releases every event that the counter held.

Event sources present an event identifier on the lookup port. One cycle later they get back the counter that should count the event and a hit flag. Counter logic uses the query port to ask whether a given counter is counting cycles or retired instructions. Fixed counter 0 always counts cycles and fixed counter 2 always counts instructions. A programmable counter answers true only when it is bound to the matching event.

Top module: `evmap_table`

## Requirements
- R1: The event identifier is selector bits [19:0]: bits [19:16] are the type and [15:0] the code (for cache-type events, code [15:3] is the cache id, [2:1] the operation and [0] the result); selector bits above 19 do not affect which event is selected. Only 0x00001 (cycles), 0x00002 (instructions), 0x10019 (data TLB read miss), 0x1001B (data TLB write miss) and 0x10021 (instruction TLB miss) are accepted. A nonzero selector carrying any other identifier is answered with wr_err=1 and leaves the table unchanged.
- R2: A write index is valid only if it is at least 3, below NUM_CTRS, and its bit in avail_mask is 1. A write to any other index is answered with wr_err=1 and leaves the table unchanged, even when the selector is zero.
- R3: A write of an all-zero selector to a valid index removes every table entry bound to that index and is answered with wr_err=0.
- R4: A valid write whose event already has an entry is answered with wr_err=0, and the existing counter for that event is kept.
- R5: A valid write of an accepted, unbound event binds that event to the written index and is answered with wr_err=0. One counter may hold several events.
- R6: wr_done is 1 in exactly the cycle after each wr_en cycle and is 0 otherwise. wr_err is only meaningful while wr_done is 1.
- R7: One cycle after lk_evt is presented, lk_hit is 1 and lk_ctr is the bound counter when that event has an entry. Otherwise lk_hit is 0 and lk_ctr is 0.
- R8: One cycle after q_ctr is presented, q_is_ins is 1 when q_ctr is 2 or when q_ctr is the nonzero counter bound to the instruction event.
- R9: One cycle after q_ctr is presented, q_is_cyc is 1 when q_ctr is 0 or when q_ctr is the nonzero counter bound to the cycle event.
- R10: A synchronous active-high reset removes all entries and clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| avail_mask | input | NUM_CTRS | One bit per counter, set when the counter is implemented |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | CTR_IW | Counter index being programmed |
| wr_sel | input | SEL_W | Event selector value |
| wr_done | output | 1 | Write response valid, one cycle after wr_en |
| wr_err | output | 1 | Write rejected |
| lk_evt | input | 20 | Event identifier to look up |
| lk_hit | output | 1 | Event has a bound counter |
| lk_ctr | output | CTR_IW | Bound counter index, 0 on miss |
| q_ctr | input | CTR_IW | Counter index to classify |
| q_is_cyc | output | 1 | Counter counts cycles |
| q_is_ins | output | 1 | Counter counts instructions |

## Verification
The bench rebinds an event that already has an entry. A table that let the last writer win would move the event to the new counter. It zero-writes a counter that holds two events; a design that cleared only one entry, or cleared by event instead of by counter, would leave a stale hit. It writes to indices 0 to 2, to an index masked off in avail_mask, and with identifiers that differ from an accepted one by a single bit. A decoder that was too loose or an index check that was off by one would report success on these and change the table. It also puts junk in the selector bits above 19 of an accepted event and writes a selector that is nonzero only above bit 19, which must be rejected rather than treated as a removal.

// File: rtl/evmap_pkg.sv
package evmap_pkg;
  localparam int EVT_W  = 20;
  localparam int NUM_EVT = 5;
  localparam int SLOT_W = $clog2(NUM_EVT);

  // slot order: cycles, instructions, dtlb read miss, dtlb write miss, itlb miss
  localparam int SLOT_CYC = 0;
  localparam int SLOT_INS = 1;

  localparam logic [EVT_W-1:0] EVT_LIST [NUM_EVT] = '{
    20'h00001, 20'h00002, 20'h10019, 20'h1001B, 20'h10021
  };
endpackage

// File: rtl/evmap_evt_dec.sv
module evmap_evt_dec
  import evmap_pkg::*;
(
  input  logic [EVT_W-1:0]  evt,
  output logic              known,
  output logic [SLOT_W-1:0] slot
);
  always_comb begin
    known = 1'b0;
    slot  = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (evt == EVT_LIST[i]) begin
        known = 1'b1;
        slot  = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/evmap_idx_chk.sv
module evmap_idx_chk #(
  parameter int NUM_CTRS = 32,
  parameter int FIRST_PROG = 3,
  localparam int CTR_IW = $clog2(NUM_CTRS)
) (
  input  logic [CTR_IW-1:0]   idx,
  input  logic [NUM_CTRS-1:0] avail_mask,
  output logic                ok
);
  logic in_range;
  always_comb begin
    in_range = ({1'b0, idx} < (CTR_IW+1)'(NUM_CTRS)) &&
               (idx >= CTR_IW'(FIRST_PROG));
    ok = in_range && avail_mask[idx];
  end
endmodule

// File: rtl/evmap_query.sv
module evmap_query #(
  parameter int CTR_IW = 5,
  parameter int FIXED_CYC = 0,
  parameter int FIXED_INS = 2
) (
  input  logic [CTR_IW-1:0] q_ctr,
  input  logic              cyc_vld,
  input  logic [CTR_IW-1:0] cyc_ctr,
  input  logic              ins_vld,
  input  logic [CTR_IW-1:0] ins_ctr,
  output logic              is_cyc,
  output logic              is_ins
);
  always_comb begin
    is_cyc = (q_ctr == CTR_IW'(FIXED_CYC)) ||
             (cyc_vld && (cyc_ctr != '0) && (cyc_ctr == q_ctr));
    is_ins = (q_ctr == CTR_IW'(FIXED_INS)) ||
             (ins_vld && (ins_ctr != '0) && (ins_ctr == q_ctr));
  end
endmodule

// File: rtl/evmap_table.sv
module evmap_table
  import evmap_pkg::*;
#(
  parameter int NUM_CTRS = 32,
  parameter int SEL_W = 64,
  localparam int CTR_IW = $clog2(NUM_CTRS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CTRS-1:0] avail_mask,
  input  logic                wr_en,
  input  logic [CTR_IW-1:0]   wr_idx,
  input  logic [SEL_W-1:0]    wr_sel,
  output logic                wr_done,
  output logic                wr_err,
  input  logic [EVT_W-1:0]    lk_evt,
  output logic                lk_hit,
  output logic [CTR_IW-1:0]   lk_ctr,
  input  logic [CTR_IW-1:0]   q_ctr,
  output logic                q_is_cyc,
  output logic                q_is_ins
);
  logic [NUM_EVT-1:0] vld_q;
  logic [CTR_IW-1:0]  ctr_q [NUM_EVT];

  logic              idx_ok;
  logic              w_known, l_known;
  logic [SLOT_W-1:0] w_slot, l_slot;
  logic              sel_zero;
  logic              qc, qi;

  evmap_idx_chk #(.NUM_CTRS(NUM_CTRS)) u_idx (
    .idx(wr_idx), .avail_mask(avail_mask), .ok(idx_ok)
  );
  evmap_evt_dec u_wdec (.evt(wr_sel[EVT_W-1:0]), .known(w_known), .slot(w_slot));
  evmap_evt_dec u_ldec (.evt(lk_evt), .known(l_known), .slot(l_slot));
  evmap_query #(.CTR_IW(CTR_IW)) u_query (
    .q_ctr(q_ctr),
    .cyc_vld(vld_q[SLOT_CYC]), .cyc_ctr(ctr_q[SLOT_CYC]),
    .ins_vld(vld_q[SLOT_INS]), .ins_ctr(ctr_q[SLOT_INS]),
    .is_cyc(qc), .is_ins(qi)
  );

  assign sel_zero = (wr_sel == '0);

  for (genvar s = 0; s < NUM_EVT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q[s] <= 1'b0;
        ctr_q[s] <= '0;
      end else if (wr_en && idx_ok) begin
        if (sel_zero) begin
          if (vld_q[s] && (ctr_q[s] == wr_idx)) vld_q[s] <= 1'b0;
        end else if (w_known && (w_slot == SLOT_W'(s)) && !vld_q[s]) begin
          vld_q[s] <= 1'b1;
          ctr_q[s] <= wr_idx;
        end
      end
    end

    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (wr_en && idx_ok && sel_zero && vld_q[s] && ctr_q[s] == wr_idx) |=> !vld_q[s]); // R3
    AST_KEEP_FIRST: assert property (@(posedge clk) disable iff (rst)
      (wr_en && idx_ok && !sel_zero && vld_q[s] && w_known && w_slot == SLOT_W'(s))
      |=> (vld_q[s] && $stable(ctr_q[s]))); // R4
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_done  <= 1'b0;
      wr_err   <= 1'b0;
      lk_hit   <= 1'b0;
      lk_ctr   <= '0;
      q_is_cyc <= 1'b0;
      q_is_ins <= 1'b0;
    end else begin
      wr_done  <= wr_en;
      wr_err   <= wr_en && (!idx_ok || (!sel_zero && !w_known));
      lk_hit   <= l_known && vld_q[l_slot];
      lk_ctr   <= (l_known && vld_q[l_slot]) ? ctr_q[l_slot] : '0;
      q_is_cyc <= qc;
      q_is_ins <= qi;
    end
  end

  AST_BAD_IDX_ERR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_ok) |=> (wr_done && wr_err)); // R2
  AST_BAD_IDX_KEEP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !idx_ok) |=> $stable(vld_q)); // R2
  AST_ZERO_OK: assert property (@(posedge clk) disable iff (rst)
    (wr_en && idx_ok && sel_zero) |=> !wr_err); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> wr_done); // R6
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> !wr_done); // R6
  AST_HIT_CTR: assert property (@(posedge clk) disable iff (rst)
    lk_hit |-> (lk_ctr >= CTR_IW'(3))); // R7
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !lk_hit |-> (lk_ctr == '0)); // R7
  AST_FIXED_INS: assert property (@(posedge clk) disable iff (rst)
    (q_ctr == CTR_IW'(2)) |=> q_is_ins); // R8
  AST_FIXED_CYC: assert property (@(posedge clk) disable iff (rst)
    (q_ctr == '0) |=> q_is_cyc); // R9
endmodule

// File: tb/evmap_table_tb_top.sv
module evmap_table_tb_top;
  localparam int NC = 32;
  localparam logic [NC-1:0] MASK = 32'hBFFF_7FF8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [4:0] wr_idx = '0;
  logic [63:0] wr_sel = '0;
  logic [19:0] lk_evt = '0;
  logic [4:0] q_ctr = 5'd1;
  logic wr_done, wr_err, lk_hit, q_is_cyc, q_is_ins;
  logic [4:0] lk_ctr;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit mv [5];
  int mc [5];

  always #5 clk = ~clk;

  evmap_table dut_i (
    .clk(clk), .rst(rst), .avail_mask(MASK),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_sel(wr_sel),
    .wr_done(wr_done), .wr_err(wr_err),
    .lk_evt(lk_evt), .lk_hit(lk_hit), .lk_ctr(lk_ctr),
    .q_ctr(q_ctr), .q_is_cyc(q_is_cyc), .q_is_ins(q_is_ins)
  );

  function automatic int slot_of(logic [19:0] e);
    case (e)
      20'h00001: return 0;
      20'h00002: return 1;
      20'h10019: return 2;
      20'h1001B: return 3;
      20'h10021: return 4;
      default:   return -1;
    endcase
  endfunction

  function automatic logic [19:0] evt_of(int s);
    case (s)
      0: return 20'h00001;
      1: return 20'h00002;
      2: return 20'h10019;
      3: return 20'h1001B;
      default: return 20'h10021;
    endcase
  endfunction

  function automatic bit idx_good(int i);
    return (i >= 3) && (i < NC) && MASK[i];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int s = 0; s < 5; s++) begin mv[s] = 0; mc[s] = 0; end
  endtask

  task automatic do_write(int idx, logic [63:0] sel, string req);
    bit exp_err;
    int s;
    s = slot_of(sel[19:0]);
    exp_err = !idx_good(idx) || (sel != 0 && s < 0);
    @(negedge clk);
    wr_en = 1; wr_idx = idx[4:0]; wr_sel = sel;
    @(negedge clk);
    wr_en = 0;
    chk(wr_done == 1'b1, "R6", wr_done, 1);
    chk(wr_err == exp_err, req, wr_err, exp_err);
    if (!exp_err) begin
      if (sel == 0) begin
        for (int k = 0; k < 5; k++) if (mv[k] && mc[k] == idx) mv[k] = 0;
      end else if (!mv[s]) begin
        mv[s] = 1; mc[s] = idx;
      end
    end
  endtask

  task automatic do_look(logic [19:0] e, int q, string req);
    int s;
    bit eh;
    int ec;
    bit ecy, ein;
    s = slot_of(e);
    eh = (s >= 0) && mv[s];
    ec = eh ? mc[s] : 0;
    ecy = (q == 0) || (mv[0] && mc[0] != 0 && mc[0] == q);
    ein = (q == 2) || (mv[1] && mc[1] != 0 && mc[1] == q);
    @(negedge clk);
    lk_evt = e; q_ctr = q[4:0];
    @(negedge clk);
    chk(lk_hit == eh, {req, " R7 hit"}, lk_hit, eh);
    chk(int'(lk_ctr) == ec, {req, " R7 ctr"}, lk_ctr, ec);
    chk(q_is_cyc == ecy, "R9", q_is_cyc, ecy);
    chk(q_is_ins == ein, "R8", q_is_ins, ein);
  endtask

  task automatic look_all(string req);
    for (int s = 0; s < 5; s++) do_look(evt_of(s), (s * 7 + 3) % NC, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    clear_model();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R10: reset state
    chk(wr_done == 0 && wr_err == 0, "R10 wr", {wr_done, wr_err}, 0);
    chk(lk_hit == 0 && lk_ctr == 0, "R10 lk", {lk_hit, lk_ctr}, 0);
    look_all("R10");

    do_write(2, 64'h1, "R2 idx2");
    do_write(0, 64'h2, "R2 idx0");
    do_write(15, 64'h1, "R2 masked");
    do_write(30, 64'h0, "R2 masked zero");
    do_write(5, 64'h1, "R5 cyc");
    @(negedge clk);
    chk(wr_done == 0, "R6 pulse", wr_done, 0);
    do_look(20'h00001, 5, "R5");
    do_look(20'h00001, 0, "R9 fixed");
    do_write(6, 64'h1, "R4 rebind");
    do_look(20'h00001, 6, "R4 kept");
    do_write(7, 64'h1234, "R1 bad evt");
    do_write(7, 64'h10018, "R1 near evt");
    do_write(7, 64'h0000_0010_0000_0000, "R1 upper only");
    do_write(7, 64'hABCD_0000_0001_0019, "R1 upper junk");
    do_look(20'h10019, 7, "R1");
    do_write(5, 64'h2, "R5 ins");
    do_look(20'h00002, 5, "R8 mapped");
    do_look(20'h00002, 2, "R8 fixed");
    do_write(5, 64'h0, "R3 zero");
    look_all("R3");
    do_look(20'h00001, 5, "R3");
    do_look(20'h10019, 7, "R3 other kept");

    for (int n = 0; n < 600; n++) begin
      int r;
      int idx;
      logic [63:0] sel;
      r = $urandom % 8;
      idx = $urandom % NC;
      case (r)
        5: sel = 64'h0;
        6: sel = {44'h0, 20'($urandom)};
        7: sel = {44'h0, evt_of($urandom % 5) ^ (20'h1 << ($urandom % 20))};
        default: sel = {($urandom % 2) ? 44'($urandom) : 44'h0, evt_of(r)};
      endcase
      do_write(idx, sel, "R1 R2 R3 R4 R5 rnd");
      do_look(evt_of($urandom % 5), $urandom % NC, "rnd");
    end

    @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    clear_model();
    chk(wr_done == 0 && lk_hit == 0, "R10 rerst", {wr_done, lk_hit}, 0);
    look_all("R10");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule